// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter that runs from a quarter-rate tick enable. Software on a small register bus can read and write three registers: the count, the period and the control byte. A prescaler can slow the tick by 1, 4 or 16. When the count reaches the period value on a prescaled tick, the counter restarts from zero and a one-clock match pulse is sent out. Another timing unit, such as a PWM generator, can use that pulse as its time base.

The match events also feed a 4-bit postscaler. After a programmed number of matches, the postscaler sets a sticky interrupt flag, which stays set until software clears it. Writing the count or the control register restarts both hidden scaler counters. A control write does not change the count value.

The counter is driven by a two-state machine. **HALT** holds the count. **RUN** advances the count on prescaled ticks. A control write with the run bit set takes the transition HALT→RUN. A control write with the run bit clear takes RUN→HALT. Reset enters HALT.

Top module: `pmt_timer`

## Requirements
- R1: After reset the outputs are as follows: count 0x00, period 0xFF, control 0x00, interrupt flag 0, match pulse 0.
- R2: A bus write selects its register with `wr_sel`: 0 selects count, 1 selects period and 2 selects control. The register shows the written value on the next cycle. Bit 7 of control always reads 0.
- R3: While running, the count advances once per 1, 4 or 16 `tick_en` pulses. The ratio is set by control[1:0]: 00 selects 1, 01 selects 4, and 1x selects 16 (bit 0 is ignored when bit 1 is set).
- R4: When control bit 2 (run) is 0, the count holds its value.
- R5: A prescaled tick that finds the count equal to the period loads the count with 0. On the next cycle, `match_o` is high for one clock and the count reads 0.
- R6: With N held in control[6:3], the interrupt flag sets on the (N+1)th match. It rises in the same cycle as that match pulse.
- R7: The interrupt flag stays set until `irq_clr` is asserted.
- R8: A write to count or control clears the prescaler and postscaler progress and cancels any tick in that cycle. A control write leaves the count unchanged.
- R9: A count write in the same cycle as a tick loads the written value, with no increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Quarter-rate tick enable |
| wr_en | input | 1 | Bus write strobe |
| wr_sel | input | 2 | Register select: 0 count, 1 period, 2 control |
| wr_data | input | 8 | Bus write data |
| irq_clr | input | 1 | Clears the interrupt flag |
| count_o | output | 8 | Count register readback |
| period_o | output | 8 | Period register readback |
| ctrl_o | output | 8 | Control register readback |
| match_o | output | 1 | One-clock period-match pulse |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
Wrong internal state shows up at the ports in different ways:
- **Stale prescaler phase:** the count steps early, within fewer than 16 ticks of a count or control write.
- **Stale postscaler phase:** the flag rises on the wrong match, so the fault is visible one period later.
- **Wrong run state:** the count moves or stalls on the first tick after a control write.

Every match pulse is compared against a predicted cycle. A missing, extra or late wrap is therefore reported in the cycle where it occurs.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_CTRL   = 2'd2
    } pmt_sel_e;

    typedef enum logic {
        TS_HALT = 1'b0,
        TS_RUN  = 1'b1
    } pmt_state_e;

    localparam int CTRL_W      = 8;
    localparam int RUN_BIT     = 2;
    localparam int POST_LO     = 3;
    localparam int POST_HI     = 6;
    localparam logic [CTRL_W-1:0] CTRL_MASK = 8'h7F;
endpackage

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
    parameter int CW = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       tick_in,
    input  logic       run,
    input  logic [1:0] ratio_sel,
    output logic       tick_out
);
    localparam logic [CW-1:0] LIM_1  = '0;
    localparam logic [CW-1:0] LIM_4  = CW'(3);
    localparam logic [CW-1:0] LIM_16 = CW'(15);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic          step;

    always_comb begin
        if (ratio_sel[1])      lim = LIM_16;
        else if (ratio_sel[0]) lim = LIM_4;
        else                   lim = LIM_1;
    end

    assign step     = tick_in && run && !clr;
    assign tick_out = step && (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= (cnt_q == lim) ? '0 : cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/pmt_postscaler.sv
module pmt_postscaler #(
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          match_in,
    input  logic [NW-1:0] limit,
    output logic          fire
);
    logic [NW-1:0] cnt_q;

    assign fire = match_in && !clr && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (match_in) begin
            cnt_q <= (cnt_q == limit) ? '0 : cnt_q + NW'(1);
        end
    end
endmodule

// File: rtl/pmt_timer.sv
module pmt_timer
    import pmt_pkg::*;
#(
    parameter int DW     = 8,
    parameter int PRE_W  = 4,
    parameter int POST_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          irq_clr,
    output logic [DW-1:0] count_o,
    output logic [DW-1:0] period_o,
    output logic [7:0]    ctrl_o,
    output logic          match_o,
    output logic          irq_o
);
    localparam logic [DW-1:0] PERIOD_RST = '1;

    pmt_state_e    state_q, state_d;
    logic [DW-1:0] count_q, period_q;
    logic [7:0]    ctrl_q;
    logic          match_q, irq_q;
    logic          wr_cnt, wr_per, wr_ctl, scaler_clr;
    logic          run, ptick, hit, fire, advance;

    assign wr_cnt     = wr_en && (wr_sel == SEL_COUNT);
    assign wr_per     = wr_en && (wr_sel == SEL_PERIOD);
    assign wr_ctl     = wr_en && (wr_sel == SEL_CTRL);
    assign scaler_clr = wr_cnt || wr_ctl;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TS_HALT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_HALT: if (wr_ctl && wr_data[RUN_BIT])  state_d = TS_RUN;
            TS_RUN:  if (wr_ctl && !wr_data[RUN_BIT]) state_d = TS_HALT;
        endcase
    end

    // state outputs
    always_comb begin
        unique case (state_q)
            TS_HALT: run = 1'b0;
            TS_RUN:  run = 1'b1;
        endcase
    end

    pmt_prescaler #(.CW(PRE_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (scaler_clr),
        .tick_in   (tick_en),
        .run       (run),
        .ratio_sel (ctrl_q[1:0]),
        .tick_out  (ptick)
    );

    assign hit     = ptick && (count_q == period_q);
    assign advance = ptick && !hit;

    pmt_postscaler #(.NW(POST_W)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (scaler_clr),
        .match_in (hit),
        .limit    (ctrl_q[POST_HI:POST_LO]),
        .fire     (fire)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            period_q <= PERIOD_RST;
            ctrl_q   <= '0;
            match_q  <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            if (wr_cnt)       count_q <= wr_data;
            else if (hit)     count_q <= '0;
            else if (advance) count_q <= count_q + DW'(1);
            if (wr_per) period_q <= wr_data;
            if (wr_ctl) ctrl_q   <= wr_data[7:0] & CTRL_MASK;
            match_q <= hit;
            if (fire)         irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;
        end
    end

    assign count_o  = count_q;
    assign period_o = period_q;
    assign ctrl_o   = ctrl_q;
    assign match_o  = match_q;
    assign irq_o    = irq_q;
endmodule

// File: rtl/pmt_timer_chk.sv
module pmt_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic [7:0] wr_data,
    input logic       irq_clr,
    input logic [7:0] count_o,
    input logic [7:0] period_o,
    input logic [7:0] ctrl_o,
    input logic       match_o,
    input logic       irq_o
);
    AST_CTRL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[7] == 1'b0); // R2
    AST_PERIOD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1) |=> period_o == $past(wr_data)); // R2
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_o[2] && !(wr_en && wr_sel == 2'd0)) |=> $stable(count_o)); // R4
    AST_MATCH_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> count_o == 8'h00); // R5
    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> match_o); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr) |=> irq_o); // R7
    AST_CTRL_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2) |=> count_o == $past(count_o)); // R8
    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> count_o == $past(wr_data)); // R9
endmodule

bind pmt_timer pmt_timer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .irq_clr  (irq_clr),
    .count_o  (count_o),
    .period_o (period_o),
    .ctrl_o   (ctrl_o),
    .match_o  (match_o),
    .irq_o    (irq_o)
);

// File: tb/test_pmt_timer.sv
`timescale 1ns/1ps
module test_pmt_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       irq_clr = 1'b0;
    logic [7:0] count_o, period_o, ctrl_o;
    logic       match_o, irq_o;

    int          n_chk = 0;
    int          n_fail = 0;
    int unsigned cyc_no = 0;
    int unsigned exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc_no <= cyc_no + 1;

    pmt_timer i_pmt_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .irq_clr(irq_clr),
        .count_o(count_o), .period_o(period_o), .ctrl_o(ctrl_o),
        .match_o(match_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: each match pulse must meet the next predicted cycle (R5)
    always @(negedge clk) begin
        if (rst_n && match_o) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R5: actual pulse at cycle %0d expected none", cyc_no);
            end else begin
                check("R5 match cycle", cyc_no, exp_q.pop_front());
            end
        end
    end

    task automatic expect_match(input int k);
        exp_q.push_back(cyc_no + k);
    endtask

    task automatic cyc(input logic t);
        tick_en = t;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) cyc(1'b1);
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d, input logic t = 1'b0);
        wr_en = 1'b1; wr_sel = s; wr_data = d; tick_en = t;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic clr_flag();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 count", count_o, 8'h00);
        check("R1 period", period_o, 8'hFF);
        check("R1 ctrl", ctrl_o, 8'h00);
        check("R1 irq", irq_o, 1'b0);
        check("R1 match", match_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        wr(2'd2, 8'h84);
        check("R2 ctrl bit7 masked", ctrl_o, 8'h04);
        check("R8 ctrl write keeps count", count_o, 8'h00);
        wr(2'd1, 8'h05);
        check("R2 period write", period_o, 8'h05);
        ticks(3);
        check("R3 divide by 1", count_o, 8'h03);

        wr(2'd2, 8'h00);
        ticks(5);
        check("R4 halted count holds", count_o, 8'h03);

        wr(2'd0, 8'h00);
        check("R2 count write", count_o, 8'h00);
        wr(2'd2, 8'h05);
        ticks(7);
        check("R3 divide by 4 partial", count_o, 8'h01);
        ticks(1);
        check("R3 divide by 4", count_o, 8'h02);
        ticks(2);
        wr(2'd0, 8'h20);
        ticks(3);
        check("R8 prescaler cleared by count write", count_o, 8'h20);
        ticks(1);
        check("R8 prescaler restart", count_o, 8'h21);

        wr(2'd2, 8'h06);
        ticks(15);
        check("R3 divide by 16 partial", count_o, 8'h21);
        ticks(1);
        check("R3 divide by 16", count_o, 8'h22);
        wr(2'd2, 8'h07);
        ticks(16);
        check("R3 ratio 11 is 16", count_o, 8'h23);

        wr(2'd2, 8'h04);
        wr(2'd0, 8'h40, 1'b1);
        check("R9 write beats tick", count_o, 8'h40);
        ticks(1);
        check("R9 increments after write", count_o, 8'h41);

        wr(2'd1, 8'h02);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h14);
        check("R6 flag clear before", irq_o, 1'b0);
        expect_match(3); expect_match(6); expect_match(9); expect_match(12);
        ticks(4);
        check("R5 wrap to zero", count_o, 8'h01);
        ticks(4);
        check("R6 no flag after 2 matches", irq_o, 1'b0);
        ticks(1);
        check("R6 flag after 3 matches", irq_o, 1'b1);
        ticks(3);
        repeat (3) cyc(1'b0);
        check("R7 flag sticky", irq_o, 1'b1);
        check("R5 all pulses seen", exp_q.size(), 0);
        clr_flag();
        check("R7 flag cleared", irq_o, 1'b0);

        wr(2'd1, 8'h01);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h0C);
        expect_match(2);
        ticks(2);
        check("R6 one match of two", irq_o, 1'b0);
        wr(2'd0, 8'h00);
        expect_match(2); expect_match(4);
        ticks(2);
        check("R8 postscaler cleared by count write", irq_o, 1'b0);
        ticks(2);
        check("R6 flag after two matches", irq_o, 1'b1);
        cyc(1'b0);
        check("R5 no pending pulses", exp_q.size(), 0);

        summary();
        $finish;
    end
endmodule